// File: doc/BRIEF.md
# Carrier-Gated Serial Receive and Handshake Control

This block sits between the serial pins and a protocol engine. It watches a carrier input and lets receive bits through only while a carrier is present. It also records, for each frame, whether the carrier dropped before the frame finished. All raw pin inputs pass through a multi-flop synchroniser into the system clock domain. The receive and transmit bit clocks are not used as clocks. They are sampled, and their edges act as enables.

Two configuration bits set how the carrier is used. In sampled mode the carrier is taken at each rising receive-clock edge, and gating follows that sample with a latency of one bit. In immediate mode the synchronised carrier gates reception directly, and any low cycle during a frame counts as a lost carrier. A third setting ignores the carrier entirely. The protocol engine downstream marks each frame end with a one-cycle strobe. The block answers with a frame-status pulse that carries the sticky lost-carrier flag.

On the transmit side, a request-to-send output rises on the first falling transmit-clock edge after data is waiting. Bit-shift strobes go out while clear-to-send stays high. If clear-to-send drops in the middle of a transfer, the transfer stops at the next bit boundary and a clear-to-send-lost pulse is raised.

Top module: `cd_rx_gate`

## Requirements
- R1: In sampled mode (cfg_immediate=0, cfg_ignore=0), a bit is accepted on a rising receive-clock edge only if the carrier was high at the previous rising receive-clock edge. An accepted bit gives a one-cycle rx_valid with the bit on rx_bit. Accepted bits appear on rx_bit in arrival order.
- R2: In immediate mode (cfg_immediate=1), a bit is accepted on a rising receive-clock edge whenever the synchronised carrier is high at that edge. There is no one-bit latency.
- R3: A frame is active from its first accepted bit. If the carrier is lost while a frame is active, a sticky lost flag is set. From then on no further bits are accepted until the frame ends.
- R4: One cycle after frame_end, frame_done pulses, and frame_cd_lost shows the sticky flag. The flag and the active state are then cleared. A carrier loss seen in the same cycle as frame_end is not counted.
- R5: In sampled mode, the carrier is checked for loss only at rising receive-clock edges. A carrier dip that falls entirely between two edges is neither a loss nor a gap in reception.
- R6: In immediate mode, any synchronised low carrier cycle during an active frame is a loss, even if it comes between receive edges.
- R7: With cfg_ignore=1, every rising receive-clock edge yields a bit whatever the carrier does, and frame_cd_lost is never 1.
- R8: In immediate mode, a change of the synchronised carrier while the synchronised receive clock is high gives a one-cycle cd_viol pulse. In sampled mode, or while the receive clock is low, no pulse is given.
- R9: rts rises on the first falling transmit-clock edge with tx_req high. On each later falling edge, tx_shift pulses once if cts is high and tx_req is still high. A falling edge with tx_req low drops rts.
- R10: After at least one bit has been shifted, a falling transmit-clock edge with cts low drops rts, pulses cts_lost and gives no shift. Before the first shift, a low cts only holds off shifting.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_clk | input | 1 | Raw receive bit clock, sampled |
| rx_data | input | 1 | Raw receive data |
| carrier | input | 1 | Raw carrier-detect, high = carrier present |
| cts | input | 1 | Raw clear-to-send, high = clear |
| tx_clk | input | 1 | Raw transmit bit clock, sampled |
| tx_req | input | 1 | Transmit data waiting (level) |
| cfg_immediate | input | 1 | 1 = immediate carrier mode, 0 = sampled |
| cfg_ignore | input | 1 | 1 = carrier ignored |
| frame_end | input | 1 | One-cycle end-of-frame strobe from the protocol engine |
| rx_valid | output | 1 | Accepted-bit strobe |
| rx_bit | output | 1 | Accepted bit value |
| frame_done | output | 1 | Frame status strobe |
| frame_cd_lost | output | 1 | Lost-carrier flag for the finished frame |
| cd_viol | output | 1 | Carrier changed while the receive clock was high (immediate mode) |
| rts | output | 1 | Request to send |
| tx_shift | output | 1 | Transmit bit-shift strobe |
| cts_lost | output | 1 | Clear-to-send lost during a transfer |

## Verification
The end-of-frame strobe and a carrier-loss event can land in the same system cycle. In that case the end of the frame must win, and the frame must report clean. The bench provokes this in immediate mode. It drops the carrier so that its synchronised copy falls exactly in the cycle where frame_end is high, and then checks that frame_cd_lost is 0. It then repeats the same stimulus with frame_end one cycle later and expects frame_cd_lost to be 1, which shows that the boundary sits exactly at that cycle.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} tx_state_t;

  function automatic logic edge_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic edge_fall(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction
endpackage

// File: rtl/cdg_sync.sv
module cdg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cdg_rx_gate.sv
module cdg_rx_gate
  import cdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rxc_s,
  input  logic rxd_s,
  input  logic cd_s,
  input  logic cfg_immediate,
  input  logic cfg_ignore,
  input  logic frame_end,
  output logic rx_valid,
  output logic rx_bit,
  output logic frame_done,
  output logic frame_cd_lost,
  output logic cd_viol
);
  logic rxc_prev, cd_prev, cd_q, lost_q, active_q;
  logic rx_rise, cd_ok, gate_open, accept, lost_now;

  assign rx_rise   = edge_rise(rxc_s, rxc_prev);
  assign cd_ok     = cfg_ignore ? 1'b1 : (cfg_immediate ? cd_s : cd_q);
  assign gate_open = cd_ok & ~lost_q;
  assign accept    = rx_rise & gate_open;
  assign lost_now  = ~cfg_ignore & active_q & ~cd_s & (cfg_immediate | rx_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_prev <= 1'b0; cd_prev <= 1'b0; cd_q <= 1'b0;
      lost_q <= 1'b0; active_q <= 1'b0;
      rx_valid <= 1'b0; rx_bit <= 1'b0;
      frame_done <= 1'b0; frame_cd_lost <= 1'b0; cd_viol <= 1'b0;
    end else begin
      rxc_prev <= rxc_s;
      cd_prev  <= cd_s;
      if (rx_rise) cd_q <= cd_s;
      rx_valid <= accept;
      if (accept) rx_bit <= rxd_s;
      frame_done    <= frame_end;
      frame_cd_lost <= frame_end & lost_q;
      cd_viol       <= cfg_immediate & (cd_s ^ cd_prev) & rxc_s;
      if (frame_end) begin
        active_q <= 1'b0;
        lost_q   <= 1'b0;
      end else begin
        if (accept)   active_q <= 1'b1;
        if (lost_now) lost_q   <= 1'b1;
      end
    end
  end

  p_valid_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_rise));
  p_lost_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_q && !frame_end) |=> !rx_valid);
  p_frame_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!lost_q && !active_q && frame_done));
  p_viol_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cd_viol |-> $past(cfg_immediate));
endmodule

// File: rtl/cdg_tx_ctl.sv
module cdg_tx_ctl
  import cdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic txc_s,
  input  logic cts_s,
  input  logic tx_req,
  output logic rts,
  output logic tx_shift,
  output logic cts_lost
);
  tx_state_t state;
  logic txc_prev, tx_fall;

  assign tx_fall = edge_fall(txc_s, txc_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE; txc_prev <= 1'b0; rts <= 1'b0;
      tx_shift <= 1'b0; cts_lost <= 1'b0;
    end else begin
      txc_prev <= txc_s;
      tx_shift <= 1'b0;
      cts_lost <= 1'b0;
      if (tx_fall) begin
        unique case (state)
          TX_IDLE: if (tx_req) begin state <= TX_WAIT; rts <= 1'b1; end
          TX_WAIT: begin
            if (!tx_req) begin state <= TX_IDLE; rts <= 1'b0; end
            else if (cts_s) begin state <= TX_SEND; tx_shift <= 1'b1; end
          end
          TX_SEND: begin
            if (!cts_s) begin state <= TX_IDLE; rts <= 1'b0; cts_lost <= 1'b1; end
            else if (!tx_req) begin state <= TX_IDLE; rts <= 1'b0; end
            else tx_shift <= 1'b1;
          end
          default: begin state <= TX_IDLE; rts <= 1'b0; end
        endcase
      end
    end
  end

  p_shift_needs_rts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_shift |-> rts);
  p_cts_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cts_lost |-> (!rts && !tx_shift && $past(state == TX_SEND)));
  p_rts_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> $past(tx_req));
endmodule

// File: rtl/cd_rx_gate.sv
module cd_rx_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_clk,
  input  logic rx_data,
  input  logic carrier,
  input  logic cts,
  input  logic tx_clk,
  input  logic tx_req,
  input  logic cfg_immediate,
  input  logic cfg_ignore,
  input  logic frame_end,
  output logic rx_valid,
  output logic rx_bit,
  output logic frame_done,
  output logic frame_cd_lost,
  output logic cd_viol,
  output logic rts,
  output logic tx_shift,
  output logic cts_lost
);
  localparam int NPINS = 5;
  logic [NPINS-1:0] raw_pins, sync_pins;

  assign raw_pins = {tx_clk, cts, carrier, rx_data, rx_clk};

  cdg_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(sync_pins)
  );

  cdg_rx_gate u_rx (
    .clk(clk), .rst_n(rst_n),
    .rxc_s(sync_pins[0]), .rxd_s(sync_pins[1]), .cd_s(sync_pins[2]),
    .cfg_immediate(cfg_immediate), .cfg_ignore(cfg_ignore), .frame_end(frame_end),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .frame_done(frame_done),
    .frame_cd_lost(frame_cd_lost), .cd_viol(cd_viol)
  );

  cdg_tx_ctl u_tx (
    .clk(clk), .rst_n(rst_n),
    .txc_s(sync_pins[4]), .cts_s(sync_pins[3]), .tx_req(tx_req),
    .rts(rts), .tx_shift(tx_shift), .cts_lost(cts_lost)
  );

  p_ignore_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ignore && $past(cfg_ignore) && $past(cfg_ignore, 2)) |-> !frame_cd_lost);
endmodule

// File: tb/test_cd_rx_gate.sv
`timescale 1ns/1ps
module test_cd_rx_gate;
  localparam int H = 4;
  logic clk = 0;
  logic rst_n = 0;
  logic rx_clk = 0, rx_data = 0, carrier = 0, cts = 0, tx_clk = 0, tx_req = 0;
  logic cfg_immediate = 0, cfg_ignore = 0, frame_end = 0;
  logic rx_valid, rx_bit, frame_done, frame_cd_lost, cd_viol, rts, tx_shift, cts_lost;

  int errors = 0, checks = 0;
  int n_valid = 0, n_viol = 0, n_shift = 0, n_ctsl = 0;
  logic [15:0] col = '0;

  always #2 clk = ~clk;

  cd_rx_gate i_cd_rx_gate (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_data(rx_data), .carrier(carrier),
    .cts(cts), .tx_clk(tx_clk), .tx_req(tx_req), .cfg_immediate(cfg_immediate),
    .cfg_ignore(cfg_ignore), .frame_end(frame_end), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .frame_done(frame_done), .frame_cd_lost(frame_cd_lost), .cd_viol(cd_viol),
    .rts(rts), .tx_shift(tx_shift), .cts_lost(cts_lost)
  );

  always @(negedge clk) begin
    if (rx_valid) begin n_valid++; col = {col[14:0], rx_bit}; end
    if (cd_viol) n_viol++;
    if (tx_shift) n_shift++;
    if (cts_lost) n_ctsl++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic imm, input logic ign);
    @(negedge clk);
    rst_n = 0; rx_clk = 0; rx_data = 0; carrier = 0; cts = 0; tx_clk = 0; tx_req = 0;
    frame_end = 0; cfg_immediate = imm; cfg_ignore = ign;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rx_one(input logic b, input bit glitch);
    rx_clk = 0; rx_data = b;
    if (glitch) begin
      carrier = 0; @(negedge clk); carrier = 1; repeat (H-1) @(negedge clk);
    end else repeat (H) @(negedge clk);
    rx_clk = 1; repeat (H) @(negedge clk);
  endtask

  task automatic end_frame(output int done, output int lost);
    frame_end = 1; @(negedge clk); frame_end = 0;
    done = frame_done; lost = frame_cd_lost;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(0, 0);
    check("R11", "outputs after reset",
          {rx_valid, rx_bit, frame_done, frame_cd_lost, cd_viol, rts, tx_shift, cts_lost}, 0);
  endtask

  task automatic t_sampled_gate;
    int base, d, l;
    logic [5:0] pat = 6'b110100;
    do_reset(0, 0);
    base = n_valid;
    rx_one(1, 0); rx_one(1, 0);
    carrier = 1;
    for (int i = 5; i >= 0; i--) rx_one(pat[i], 0);
    check("R1", "sampled accepted count", n_valid - base, 5);
    check("R1", "sampled bit order", int'(col[4:0]), int'(pat[4:0]));
    end_frame(d, l);
    check("R4", "frame_done pulse", d, 1);
    check("R4", "clean frame lost flag", l, 0);
  endtask

  task automatic t_immediate_gate;
    int base;
    logic [5:0] pat = 6'b101101;
    do_reset(1, 0);
    base = n_valid;
    rx_one(0, 0);
    carrier = 1;
    for (int i = 5; i >= 0; i--) rx_one(pat[i], 0);
    check("R2", "immediate accepted count", n_valid - base, 6);
    check("R2", "immediate bit order", int'(col[5:0]), int'(pat));
  endtask

  task automatic t_sampled_lost;
    int base, d, l;
    do_reset(0, 0);
    base = n_valid;
    carrier = 1;
    repeat (3) rx_one(1, 0);
    carrier = 0;
    repeat (2) rx_one(0, 0);
    carrier = 1;
    repeat (2) rx_one(1, 0);
    check("R3", "bits blocked after loss", n_valid - base, 3);
    end_frame(d, l);
    check("R3", "sampled lost flag", l, 1);
  endtask

  task automatic t_sampled_glitch;
    int base, d, l;
    do_reset(0, 0);
    base = n_valid;
    carrier = 1;
    repeat (3) rx_one(1, 0);
    rx_one(0, 1);
    rx_one(1, 0);
    check("R5", "glitch between edges keeps reception", n_valid - base, 4);
    end_frame(d, l);
    check("R5", "glitch not a loss", l, 0);
  endtask

  task automatic t_immediate_glitch;
    int base, d, l;
    do_reset(1, 0);
    base = n_valid;
    carrier = 1;
    repeat (3) rx_one(1, 0);
    rx_one(0, 1);
    rx_one(1, 0);
    check("R6", "immediate glitch stops reception", n_valid - base, 3);
    end_frame(d, l);
    check("R6", "immediate glitch is a loss", l, 1);
  endtask

  task automatic t_ignore;
    int base, d, l;
    do_reset(0, 1);
    base = n_valid;
    repeat (2) rx_one(1, 0);
    carrier = 1; rx_one(0, 0);
    carrier = 0; rx_one(1, 0);
    check("R7", "ignore accepts every bit", n_valid - base, 4);
    end_frame(d, l);
    check("R7", "ignore never lost", l, 0);
  endtask

  task automatic t_boundary(input int extra, input int exp_lost);
    int d, l;
    do_reset(1, 0);
    carrier = 1;
    repeat (4) rx_one(1, 0);
    carrier = 0;
    repeat (2 + extra) @(negedge clk);
    end_frame(d, l);
    check("R4", $sformatf("loss vs frame_end offset %0d", extra), l, exp_lost);
    check("R4", "frame_done at boundary", d, 1);
  endtask

  task automatic t_viol;
    int base;
    do_reset(1, 0);
    base = n_viol;
    rx_clk = 1; repeat (H) @(negedge clk);
    carrier = 1; repeat (6) @(negedge clk);
    check("R8", "change during high clock", n_viol - base, 1);
    rx_clk = 0; repeat (H) @(negedge clk);
    carrier = 0; repeat (6) @(negedge clk);
    check("R8", "change during low clock", n_viol - base, 1);
    cfg_immediate = 0;
    rx_clk = 1; repeat (H) @(negedge clk);
    carrier = 1; repeat (6) @(negedge clk);
    check("R8", "sampled mode no flag", n_viol - base, 1);
  endtask

  task automatic tx_period;
    tx_clk = 1; repeat (H) @(negedge clk);
    tx_clk = 0; repeat (H) @(negedge clk);
  endtask

  task automatic t_rts;
    int base;
    do_reset(0, 0);
    base = n_shift;
    cts = 1; tx_req = 1;
    tx_clk = 1; repeat (H) @(negedge clk);
    check("R9", "rts before falling edge", rts, 0);
    tx_clk = 0; repeat (H) @(negedge clk);
    check("R9", "rts after first falling edge", rts, 1);
    check("R9", "no shift on rts edge", n_shift - base, 0);
    repeat (3) tx_period();
    check("R9", "shift count", n_shift - base, 3);
    tx_req = 0; tx_period();
    check("R9", "rts drop on no request", rts, 0);
    check("R9", "no shift after request end", n_shift - base, 3);
  endtask

  task automatic t_cts;
    int bs, bl;
    do_reset(0, 0);
    bs = n_shift; bl = n_ctsl;
    tx_req = 1; cts = 0;
    repeat (3) tx_period();
    check("R10", "wait holds rts", rts, 1);
    check("R10", "no shift without cts", n_shift - bs, 0);
    check("R10", "no loss before first shift", n_ctsl - bl, 0);
    cts = 1; tx_period();
    check("R10", "shift once cleared", n_shift - bs, 1);
    cts = 0; tx_period();
    check("R10", "cts lost pulse", n_ctsl - bl, 1);
    check("R10", "rts dropped on cts loss", rts, 0);
    check("R10", "no shift on loss edge", n_shift - bs, 1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset();
    t_sampled_gate();
    t_immediate_gate();
    t_sampled_lost();
    t_sampled_glitch();
    t_immediate_glitch();
    t_ignore();
    t_boundary(0, 0);
    t_boundary(1, 1);
    t_viol();
    t_rts();
    t_cts();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule